// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside a processor's status register, banked register file and fetch unit. Each cycle it looks at seven exception request lines. It picks the single highest-priority request that is not masked and works out the complete set of register updates that entering that exception requires. Those updates are the new status word, the copy of the old status word to be saved in the target mode's bank, the return address for the target mode's link register, and the vector address for the program counter. It presents them one clock later together with write strobes.

A return command makes the block restore the interrupted context instead. The status word is reloaded from the saved copy that the register file reads out of the current bank, and the program counter is reloaded from the current link register. The register file uses the mode field of the new status word to choose which bank receives the saved-status and link writes.

Request, return and configuration pins are plain level signals with no handshake. The block never stalls: every cycle produces either one entry, one return or nothing.

Top module: `exc_sequencer`

## Requirements
- R1: Request bit positions are reset 0, undefined instruction 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 5, FIQ 6. When several eligible requests are active, exactly one is taken, in the order reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R2: An IRQ request is ignored while status bit 7 (I) is 1, and an FIQ request is ignored while status bit 6 (F) is 1. A lower-priority eligible request is taken instead.
- R3: On entry the new status word keeps the current word's other bits, including flags 31:28. Bit 5 (T) is cleared. Bits 4:0 take the target mode: reset and software interrupt 5'b10011, both aborts 5'b10111, undefined 5'b11011, IRQ 5'b10010, FIQ 5'b10001.
- R4: On entry bit 7 (I) is set for every exception. Bit 6 (F) is set on reset and FIQ entry and otherwise keeps its current value.
- R5: On entry the saved-status output equals the current status word and the link output equals the current program counter, both as sampled in the request cycle.
- R6: On entry the program counter output is the base plus the offset. Offsets are reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18 and FIQ 0x1C. The base is 0x00000000, or 0xFFFF0000 when the high-vector input is 1.
- R7: On a return command with no eligible request, the status output takes the banked saved status and the program counter output takes the banked link value. Only the status and program counter strobes are raised.
- R8: An eligible request takes precedence over a return command in the same cycle.
- R9: Outputs are registered one cycle after the sampled inputs. An entry raises all four strobes together for that one clock. A cycle with no eligible request and no return raises no strobe.
- R10: While reset is active all strobes are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 7 | Exception request lines, bit positions per R1 |
| ret_cmd | input | 1 | Return-from-exception command |
| hi_vec | input | 1 | Selects the high vector base |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Return address of the interrupted instruction stream |
| bank_spsr | input | 32 | Saved status read from the current mode's bank |
| bank_lr | input | 32 | Link value read from the current mode's bank |
| psr_out | output | 32 | New status word |
| psr_we | output | 1 | Status write strobe |
| spsr_out | output | 32 | Status value to save in the target bank |
| spsr_we | output | 1 | Saved-status write strobe |
| lr_out | output | 32 | Return address for the target bank's link register |
| lr_we | output | 1 | Link write strobe |
| pc_out | output | 32 | New program counter |
| pc_we | output | 1 | Program counter write strobe |

## Verification
The block holds no state beyond its output registers, so any wrong decision shows at the ports on the very next clock. A wrong arbitration or mask decision gives a wrong vector and mode field. A wrong status build shows as a stray T bit, a missing I or F bit, or a damaged flag nibble. A wrong choice between return and entry shows as the wrong pattern of strobes. Each stimulus is therefore checked one cycle after it is applied. The strobe pattern and the status and program counter values are compared every cycle, and the saved-status and link values are compared whenever their strobes are high.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_SRC  = 7;
  localparam int WORD_W   = 32;
  localparam int MODE_W   = 5;
  localparam int IDX_W    = $clog2(NUM_SRC);

  localparam int SRC_RST  = 0;
  localparam int SRC_UND  = 1;
  localparam int SRC_SWI  = 2;
  localparam int SRC_PABT = 3;
  localparam int SRC_DABT = 4;
  localparam int SRC_IRQ  = 5;
  localparam int SRC_FIQ  = 6;

  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;

  // rank 0 is the highest priority
  function automatic int prio_src(input int rank);
    case (rank)
      0:       return SRC_RST;
      1:       return SRC_DABT;
      2:       return SRC_FIQ;
      3:       return SRC_IRQ;
      4:       return SRC_PABT;
      5:       return SRC_UND;
      default: return SRC_SWI;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] src_mode(input int src);
    case (src)
      SRC_RST, SRC_SWI:   return MODE_SVC;
      SRC_PABT, SRC_DABT: return MODE_ABT;
      SRC_UND:            return MODE_UND;
      SRC_IRQ:            return MODE_IRQ;
      default:            return MODE_FIQ;
    endcase
  endfunction

  // word slot in the vector table; slot 5 is left unused
  function automatic logic [2:0] src_slot(input int src);
    case (src)
      SRC_RST:  return 3'd0;
      SRC_UND:  return 3'd1;
      SRC_SWI:  return 3'd2;
      SRC_PABT: return 3'd3;
      SRC_DABT: return 3'd4;
      SRC_IRQ:  return 3'd6;
      default:  return 3'd7;
    endcase
  endfunction

  function automatic logic src_sets_f(input int src);
    return (src == SRC_RST) || (src == SRC_FIQ);
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N = NUM_SRC,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          i_mask,
  input  logic          f_mask,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          grant_any
);
  logic [N-1:0] mask_vec;
  logic [N-1:0] elig;

  always_comb begin
    mask_vec          = '0;
    mask_vec[SRC_IRQ] = i_mask;
    mask_vec[SRC_FIQ] = f_mask;
  end

  assign elig      = req & ~mask_vec;
  assign grant_any = |elig;

  always_comb begin
    logic found;
    found     = 1'b0;
    grant     = '0;
    grant_idx = '0;
    for (int r = 0; r < N; r++) begin
      int s;
      s = prio_src(r);
      if (!found && elig[s]) begin
        found     = 1'b1;
        grant[s]  = 1'b1;
        grant_idx = IW'(s);
      end
    end
  end

  // R1: never more than one winner, and a winner whenever a request is eligible
  a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_any == (grant != '0)));
  // R2: masked sources never win
  a_r2_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    i_mask |-> !grant[SRC_IRQ]);
  a_r2_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    f_mask |-> !grant[SRC_FIQ]);
  // R1: reset request always wins
  a_r1_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req[SRC_RST] |-> grant[SRC_RST]);
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int                W       = WORD_W,
  parameter logic [W-1:0]      LO_BASE = '0,
  parameter logic [W-1:0]      HI_BASE = 32'hFFFF_0000,
  localparam int               IW      = IDX_W
) (
  input  logic [IW-1:0] src_idx,
  input  logic [W-1:0]  cur_psr,
  input  logic          hi_vec,
  output logic [W-1:0]  ent_psr,
  output logic [W-1:0]  ent_vec
);
  logic [W-1:0] base;

  always_comb begin
    int s;
    s                      = int'(src_idx);
    ent_psr                = cur_psr;
    ent_psr[MODE_W-1:0]    = src_mode(s);
    ent_psr[BIT_T]         = 1'b0;
    ent_psr[BIT_I]         = 1'b1;
    if (src_sets_f(s))
      ent_psr[BIT_F]       = 1'b1;
  end

  assign base    = hi_vec ? HI_BASE : LO_BASE;
  assign ent_vec = base | W'({src_slot(int'(src_idx)), 2'b00});
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int           W       = WORD_W,
  parameter int           N       = NUM_SRC,
  parameter logic [W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] exc_req,
  input  logic         ret_cmd,
  input  logic         hi_vec,
  input  logic [W-1:0] cur_psr,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] bank_spsr,
  input  logic [W-1:0] bank_lr,
  output logic [W-1:0] psr_out,
  output logic         psr_we,
  output logic [W-1:0] spsr_out,
  output logic         spsr_we,
  output logic [W-1:0] lr_out,
  output logic         lr_we,
  output logic [W-1:0] pc_out,
  output logic         pc_we
);
  localparam int IW = $clog2(N);

  logic [N-1:0]  grant;
  logic [IW-1:0] grant_idx;
  logic          grant_any;
  logic [W-1:0]  ent_psr;
  logic [W-1:0]  ent_vec;

  exc_arbiter #(.N(N)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (exc_req),
    .i_mask    (cur_psr[BIT_I]),
    .f_mask    (cur_psr[BIT_F]),
    .grant     (grant),
    .grant_idx (grant_idx),
    .grant_any (grant_any)
  );

  exc_entry_calc #(.W(W), .HI_BASE(HI_BASE)) u_calc (
    .src_idx (grant_idx),
    .cur_psr (cur_psr),
    .hi_vec  (hi_vec),
    .ent_psr (ent_psr),
    .ent_vec (ent_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psr_out  <= '0;
      spsr_out <= '0;
      lr_out   <= '0;
      pc_out   <= '0;
      psr_we   <= 1'b0;
      spsr_we  <= 1'b0;
      lr_we    <= 1'b0;
      pc_we    <= 1'b0;
    end else if (grant_any) begin
      psr_out  <= ent_psr;
      spsr_out <= cur_psr;
      lr_out   <= cur_pc;
      pc_out   <= ent_vec;
      psr_we   <= 1'b1;
      spsr_we  <= 1'b1;
      lr_we    <= 1'b1;
      pc_we    <= 1'b1;
    end else if (ret_cmd) begin
      psr_out  <= bank_spsr;
      pc_out   <= bank_lr;
      psr_we   <= 1'b1;
      spsr_we  <= 1'b0;
      lr_we    <= 1'b0;
      pc_we    <= 1'b1;
    end else begin
      psr_we   <= 1'b0;
      spsr_we  <= 1'b0;
      lr_we    <= 1'b0;
      pc_we    <= 1'b0;
    end
  end

  // R9: entry strobes move as a group
  a_r9_entry_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (psr_we && lr_we && pc_we));
  // R7: a status write without a save is a return and also reloads the PC
  a_r7_return_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_we && !spsr_we) |-> (pc_we && !lr_we));
  // R3: entry always lands in the 32-bit state
  a_r3_t_clear: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> !psr_out[BIT_T]);
  // R4: entry always masks IRQ
  a_r4_i_set: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> psr_out[BIT_I]);
  // R6: vectors are word aligned within the first 32 bytes of a base
  a_r6_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (pc_out[1:0] == 2'b00));
  // R8: an eligible request is never turned into a return
  a_r8_entry_over_return: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> spsr_we);
  // R10: first cycle after reset shows no strobe
  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !(psr_we || spsr_we || lr_we || pc_we));
endmodule

// File: tb/exc_sequencer_test.sv
`timescale 1ns/1ps
module exc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic        ret_cmd = 1'b0;
  logic        hi_vec = 1'b0;
  logic [31:0] cur_psr = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] bank_spsr = 32'h8000_0030;
  logic [31:0] bank_lr = 32'h0000_1234;
  logic [31:0] psr_out, spsr_out, lr_out, pc_out;
  logic        psr_we, spsr_we, lr_we, pc_we;

  int applied = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_cmd(ret_cmd),
    .hi_vec(hi_vec), .cur_psr(cur_psr), .cur_pc(cur_pc),
    .bank_spsr(bank_spsr), .bank_lr(bank_lr),
    .psr_out(psr_out), .psr_we(psr_we), .spsr_out(spsr_out), .spsr_we(spsr_we),
    .lr_out(lr_out), .lr_we(lr_we), .pc_out(pc_out), .pc_we(pc_we)
  );

  typedef struct packed {
    logic [6:0]  req;
    logic        ret;
    logic        hv;
    logic [31:0] psr;
    logic [31:0] exp_psr;
    logic [31:0] exp_pc;
    logic [3:0]  exp_we;   // {psr, spsr, lr, pc}
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{7'h01, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_00D3, 32'h0000_0000, 4'hF}, // R3 R4 R6 reset
    '{7'h02, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_009B, 32'h0000_0004, 4'hF}, // undefined
    '{7'h04, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0093, 32'h0000_0008, 4'hF}, // software int
    '{7'h08, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0097, 32'h0000_000C, 4'hF}, // prefetch abort
    '{7'h10, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0097, 32'h0000_0010, 4'hF}, // data abort
    '{7'h20, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0092, 32'h0000_0018, 4'hF}, // IRQ
    '{7'h40, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_00D1, 32'h0000_001C, 4'hF}, // FIQ
    '{7'h40, 1'b0, 1'b1, 32'hA000_0010, 32'hA000_00D1, 32'hFFFF_001C, 4'hF}, // R6 high base
    '{7'h7F, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_00D3, 32'h0000_0000, 4'hF}, // R1 all
    '{7'h7E, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0097, 32'h0000_0010, 4'hF}, // R1 dabt
    '{7'h6E, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_00D1, 32'h0000_001C, 4'hF}, // R1 fiq
    '{7'h2E, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0092, 32'h0000_0018, 4'hF}, // R1 irq
    '{7'h0E, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_0097, 32'h0000_000C, 4'hF}, // R1 pabt
    '{7'h06, 1'b0, 1'b0, 32'h6000_0030, 32'h6000_009B, 32'h0000_0004, 4'hF}, // R1 und
    '{7'h20, 1'b0, 1'b0, 32'h6000_00B0, 32'h0000_0000, 32'h0000_0000, 4'h0}, // R2 irq masked
    '{7'h60, 1'b0, 1'b0, 32'h6000_0070, 32'h6000_00D2, 32'h0000_0018, 4'hF}, // R2 fiq masked
    '{7'h00, 1'b1, 1'b0, 32'h6000_0093, 32'h8000_0030, 32'h0000_1234, 4'h9}, // R7 return
    '{7'h02, 1'b1, 1'b0, 32'h6000_0093, 32'h6000_009B, 32'h0000_0004, 4'hF}, // R8 entry wins
    '{7'h00, 1'b0, 1'b0, 32'h6000_0093, 32'h0000_0000, 32'h0000_0000, 4'h0}  // R9 idle
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    applied++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {psr_we, spsr_we, lr_we, pc_we};
  endfunction

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(strobes() == 4'h0, "R10 strobes", {28'h0, strobes()}, 32'h0);
    check(psr_out == 0 && pc_out == 0, "R10 psr/pc", psr_out | pc_out, 32'h0);
    check(spsr_out == 0 && lr_out == 0, "R10 spsr/lr", spsr_out | lr_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      exc_req = VECS[i].req;
      ret_cmd = VECS[i].ret;
      hi_vec  = VECS[i].hv;
      cur_psr = VECS[i].psr;
      cur_pc  = 32'h0000_0100 + 32'(i) * 4;
      @(negedge clk);
      check(strobes() == VECS[i].exp_we, "R9 strobes", {28'h0, strobes()},
            {28'h0, VECS[i].exp_we});
      if (VECS[i].exp_we[3])
        check(psr_out == VECS[i].exp_psr, "R3 R4 R7 status", psr_out, VECS[i].exp_psr);
      if (VECS[i].exp_we[0])
        check(pc_out == VECS[i].exp_pc, "R6 R7 pc", pc_out, VECS[i].exp_pc);
      if (VECS[i].exp_we[2])
        check(spsr_out == VECS[i].psr, "R5 saved status", spsr_out, VECS[i].psr);
      if (VECS[i].exp_we[1])
        check(lr_out == 32'h0000_0100 + 32'(i) * 4, "R5 link", lr_out,
              32'h0000_0100 + 32'(i) * 4);
    end

    // R9: a request held for two cycles enters in each, strobes drop after release
    exc_req = 7'h04; cur_psr = 32'h0000_0010; cur_pc = 32'h0000_2000;
    @(negedge clk);
    check(strobes() == 4'hF, "R9 first cycle", {28'h0, strobes()}, 32'hF);
    @(negedge clk);
    check(strobes() == 4'hF, "R9 second cycle", {28'h0, strobes()}, 32'hF);
    exc_req = 7'h00;
    @(negedge clk);
    check(strobes() == 4'h0, "R9 released", {28'h0, strobes()}, 32'h0);

    // R10: reset in the middle of a request clears everything
    exc_req = 7'h10; rst_n = 1'b0;
    @(negedge clk);
    check(strobes() == 4'h0, "R10 mid-run strobes", {28'h0, strobes()}, 32'h0);
    check(pc_out == 0 && psr_out == 0, "R10 mid-run data", pc_out | psr_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc_out == 32'h10, "R6 after reset release", pc_out, 32'h10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule